// File: doc/BRIEF.md
# Interrupt Latch with Strobe-Driven Serial Timebase

This block gathers the interrupt sources of a small 8-bit processor into one byte that the processor reads on its data bus. The low seven bits follow external request lines after they cross into the system clock domain. The top bit is a sticky periodic tick. The processor clears that bit by reading the interrupt byte.

The block has no free-running oscillator divider. It takes its timebase from the processor's own write strobe, which fires exactly once per instruction. Each write strobe toggles a serial bit clock, so a 76800 Hz strobe rate gives a 38400 Hz bit clock. A counter on the bit clock divides it by 16 to give the 2400 Hz tick. A serial transmitter or receiver elsewhere uses the bit clock.

The bus decoder asserts an address-match input when the processor reads the interrupt address (0xFF). That address is read-only. While such a read is in progress, the block raises a bus-drive enable.

Top module: `irq_timebase`

## Requirements
- R1: Reset (active-low `rst_n`) clears the bit clock to 0, clears the tick counter and clears bit 7 of `irq_byte`. After reset, the first tick comes on the 15th write strobe.
- R2: On every clock edge where `wr_stb` is 1, `bit_clk` inverts. On every other edge it holds its value.
- R3: The tick sets `irq_byte[7]` at the clock edge where `wr_stb` drives the 8th rising transition of `bit_clk` in a 16-transition cycle. This is write strobe 15 after reset, and every 32nd write strobe after that (47, 79, ...).
- R4: Once set, `irq_byte[7]` stays 1 through any number of further write strobes until a clearing read.
- R5: A clock edge with `rd_stb` and `rd_addr_hit` both 1 clears `irq_byte[7]`. During that read cycle, `irq_byte[7]` still shows 1.
- R6: If a tick and a clearing read fall on the same clock edge, `irq_byte[7]` stays 1.
- R7: A read strobe without `rd_addr_hit` leaves `irq_byte[7]` unchanged and keeps `bus_drive` at 0.
- R8: `irq_byte[6:0]` shows the level of `ext_irq[6:0]` two clock edges after it changes, and not one edge after. The low bits are not latched: when an input returns low, its bit returns low two edges later.
- R9: `bus_drive` is 1 exactly while `rd_stb` and `rd_addr_hit` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe, one clock wide, once per instruction |
| rd_stb | input | 1 | Read strobe, one clock wide |
| rd_addr_hit | input | 1 | The read address equals 0xFF |
| ext_irq | input | 7 | External interrupt request levels, asynchronous |
| bit_clk | output | 1 | Serial bit clock, half the write strobe rate |
| irq_byte | output | 8 | Interrupt byte: bit 7 is the sticky tick, bits 6:0 are the synchronized external lines |
| bus_drive | output | 1 | Enable for driving `irq_byte` onto the data bus |

## Verification
The assertions assume that `wr_stb` is the only cause of a tick. Under that assumption, a clearing read on an edge without a write strobe must leave bit 7 low, and an edge without a strobe can never set it. They also assume that reset is held long enough to reach the first clock edge.

The stimulus uses eight-clock frames: the write strobe comes in the first cycle and any read comes in the fifth, as on the processor bus. The only exception is one deliberate frame in which the read is placed on the same edge as the tick-producing strobe, to cover the collision rule.

// File: rtl/irq_timebase_pkg.sv
package irq_timebase_pkg;
   localparam int DEF_EXT_LINES = 7;
   localparam int DEF_SYNC_STAGES = 2;
   localparam int DEF_DIV_LOG2 = 4;

   function automatic logic bus_select(input logic rd, input logic hit);
      return rd & hit;
   endfunction
endpackage

// File: rtl/strobe_divider.sv
module strobe_divider (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   output logic bit_clk,
   output logic rise
);
   always_ff @(posedge clk) begin
      if (!rst_n)      bit_clk <= 1'b0;
      else if (wr_stb) bit_clk <= ~bit_clk;
   end

   assign rise = wr_stb & ~bit_clk;
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int DIV_LOG2 = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   output logic tick_set
);
   localparam int HALF = 2 ** (DIV_LOG2 - 1);
   localparam logic [DIV_LOG2-1:0] EDGE_AT = DIV_LOG2'(HALF - 1);

   logic [DIV_LOG2-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (rise) cnt <= cnt + 1'b1;
   end

   assign tick_set = rise && (cnt == EDGE_AT);
endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
   parameter int EXT_W  = 7,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_set,
   input  logic             rd_clr,
   input  logic [EXT_W-1:0] ext_irq,
   output logic [EXT_W:0]   irq_byte
);
   logic [EXT_W-1:0] sync_q [STAGES];
   logic             sticky;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[s] <= '0;
               else        sync_q[s] <= ext_irq;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[s] <= '0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        sticky <= 1'b0;
      else if (tick_set) sticky <= 1'b1;
      else if (rd_clr)   sticky <= 1'b0;
   end

   assign irq_byte = {sticky, sync_q[STAGES-1]};
endmodule

// File: rtl/irq_timebase.sv
module irq_timebase
   import irq_timebase_pkg::*;
#(
   parameter int EXT_W       = DEF_EXT_LINES,
   parameter int SYNC_STAGES = DEF_SYNC_STAGES,
   parameter int DIV_LOG2    = DEF_DIV_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic             rd_stb,
   input  logic             rd_addr_hit,
   input  logic [EXT_W-1:0] ext_irq,
   output logic             bit_clk,
   output logic [EXT_W:0]   irq_byte,
   output logic             bus_drive
);
   generate
      if (EXT_W < 1 || EXT_W > 15) begin : g_bad_width
         $error("irq_timebase: EXT_W out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_timebase: SYNC_STAGES below 2");
      end
      if (DIV_LOG2 < 1 || DIV_LOG2 > 16) begin : g_bad_div
         $error("irq_timebase: DIV_LOG2 out of range");
      end
   endgenerate

   logic rise;
   logic tick_set;
   logic rd_clr;

   assign rd_clr    = bus_select(rd_stb, rd_addr_hit);
   assign bus_drive = rd_clr;

   strobe_divider u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .bit_clk (bit_clk),
      .rise    (rise)
   );

   tick_counter #(.DIV_LOG2(DIV_LOG2)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (rise),
      .tick_set (tick_set)
   );

   irq_collector #(.EXT_W(EXT_W), .STAGES(SYNC_STAGES)) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_set (tick_set),
      .rd_clr   (rd_clr),
      .ext_irq  (ext_irq),
      .irq_byte (irq_byte)
   );
endmodule

// File: rtl/irq_timebase_chk.sv
module irq_timebase_chk #(
   parameter int EXT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_stb,
   input logic             rd_stb,
   input logic             rd_addr_hit,
   input logic [EXT_W-1:0] ext_irq,
   input logic             bit_clk,
   input logic [EXT_W:0]   irq_byte,
   input logic             bus_drive
);
   a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> bit_clk != $past(bit_clk));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(bit_clk));

   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_byte[EXT_W] && !(rd_stb && rd_addr_hit)) |=> irq_byte[EXT_W]);

   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_addr_hit && !wr_stb) |=> !irq_byte[EXT_W]);

   a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !irq_byte[EXT_W]) |=> !irq_byte[EXT_W]);

   a_r9_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |-> !bus_drive);

   a_r7_no_drive_miss: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_addr_hit |-> !bus_drive);
endmodule

bind irq_timebase irq_timebase_chk #(.EXT_W(EXT_W)) u_chk (.*);

// File: tb/sim_irq_timebase.sv
module sim_irq_timebase;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_stb = 1'b0;
   logic       rd_stb = 1'b0;
   logic       rd_addr_hit = 1'b0;
   logic [6:0] ext_irq = '0;
   logic       bit_clk;
   logic [7:0] irq_byte;
   logic       bus_drive;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_timebase u0 (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .rd_addr_hit(rd_addr_hit), .ext_irq(ext_irq), .bit_clk(bit_clk),
      .irq_byte(irq_byte), .bus_drive(bus_drive)
   );

   localparam int NV = 8;
   localparam logic [6:0] VEC_IN [NV] = '{7'h00, 7'h7F, 7'h55, 7'h2A,
                                         7'h01, 7'h40, 7'h13, 7'h00};

   task automatic check(input string req, input logic [7:0] act,
                        input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic edge1();
      @(posedge clk); #1;
   endtask

   // One eight-clock frame: strobe in cycle 0 (optionally with a clearing read),
   // optional read in cycle 4.
   task automatic frame(input bit do_wr, input bit rd_same, input bit rd_late,
                        input bit hit_late);
      @(negedge clk);
      wr_stb = do_wr; rd_stb = rd_same; rd_addr_hit = rd_same;
      edge1();
      @(negedge clk);
      wr_stb = 0; rd_stb = 0; rd_addr_hit = 0;
      repeat (3) edge1();
      @(negedge clk);
      rd_stb = rd_late; rd_addr_hit = hit_late;
      edge1();
      @(negedge clk);
      rd_stb = 0; rd_addr_hit = 0;
      repeat (3) edge1();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; wr_stb = 0; rd_stb = 0; rd_addr_hit = 0;
      repeat (2) edge1();
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      check("R1 bit_clk", {7'b0, bit_clk}, 8'h00);
      check("R1 bit7", {7'b0, irq_byte[7]}, 8'h00);
      check("R9 idle drive", {7'b0, bus_drive}, 8'h00);

      // R8: vector table of external levels
      for (int i = 1; i < NV; i++) begin
         @(negedge clk);
         ext_irq = VEC_IN[i];
         edge1();
         check("R8 one edge", {1'b0, irq_byte[6:0]}, {1'b0, VEC_IN[i-1]});
         edge1();
         check("R8 two edges", {1'b0, irq_byte[6:0]}, {1'b0, VEC_IN[i]});
      end

      // R2/R3: strobes 1..14, no tick
      for (int k = 1; k <= 14; k++) begin
         frame(1, 0, 0, 0);
         check("R2 bit_clk", {7'b0, bit_clk}, {7'b0, k[0]});
      end
      check("R3 no tick before 15", {7'b0, irq_byte[7]}, 8'h00);
      @(negedge clk); wr_stb = 1; edge1();
      check("R3 tick at strobe 15", {7'b0, irq_byte[7]}, 8'h01);
      @(negedge clk); wr_stb = 0; repeat (7) edge1();

      // R4: sticky through 16 more strobes (31 total)
      for (int k = 0; k < 16; k++) frame(1, 0, 0, 0);
      check("R4 sticky", {7'b0, irq_byte[7]}, 8'h01);

      // R7: read without address hit
      @(negedge clk); rd_stb = 1; rd_addr_hit = 0; #1;
      check("R7 no drive", {7'b0, bus_drive}, 8'h00);
      edge1();
      @(negedge clk); rd_stb = 0;
      check("R7 bit kept", {7'b0, irq_byte[7]}, 8'h01);

      // R5/R9: clearing read
      @(negedge clk); rd_stb = 1; rd_addr_hit = 1; #1;
      check("R9 drive", {7'b0, bus_drive}, 8'h01);
      check("R5 visible during read", {7'b0, irq_byte[7]}, 8'h01);
      edge1();
      @(negedge clk); rd_stb = 0; rd_addr_hit = 0; #1;
      check("R5 cleared", {7'b0, irq_byte[7]}, 8'h00);
      check("R9 drive off", {7'b0, bus_drive}, 8'h00);

      // R6: strobes 32..46, then 47 coincides with a clearing read
      for (int k = 32; k <= 46; k++) frame(1, 0, 1, 1);
      check("R3 no tick before 47", {7'b0, irq_byte[7]}, 8'h00);
      @(negedge clk); wr_stb = 1; rd_stb = 1; rd_addr_hit = 1; edge1();
      check("R6 tick wins", {7'b0, irq_byte[7]}, 8'h01);
      @(negedge clk); wr_stb = 0; rd_stb = 0; rd_addr_hit = 0;
      repeat (7) edge1();
      frame(0, 0, 1, 1);
      check("R5 cleared again", {7'b0, irq_byte[7]}, 8'h00);

      // R1: reset mid-cycle restarts the divider
      frame(1, 0, 0, 0);
      do_reset();
      check("R1 bit_clk after reset", {7'b0, bit_clk}, 8'h00);
      check("R1 sync cleared", {1'b0, irq_byte[6:0]}, 8'h00);
      for (int k = 1; k <= 14; k++) frame(1, 0, 0, 0);
      check("R1 no early tick", {7'b0, irq_byte[7]}, 8'h00);
      frame(1, 0, 0, 0);
      check("R1 tick at 15 after reset", {7'b0, irq_byte[7]}, 8'h01);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule